// File: doc/BRIEF.md
# Level-Sensed Single-Address DMA Channel

This block is one DMA channel started by an active-low external request line. Each transfer is a single bus cycle. In that cycle the channel drives a memory address and a read/write strobe, and it acknowledges the external device. The device then supplies or takes the data directly. No data passes through the channel.

Software programs a start address, a transfer count and a control word. The control word holds enable, level-activation mode, data size and direction. While the channel is enabled and idle, it samples the request line on every rising clock edge and latches a low level as a pending request.

A pending request makes the channel ask an arbiter for the bus and wait for grant. It then runs one transfer cycle and drops its bus request for one cycle, which forms a bus break. Sampling resumes only after that break. The count decreases once per transfer. When the last transfer ends, the channel disables itself and pulses a done output.

Top module: `dma_lvl_chan`

## Requirements
- R1: After a synchronous reset, `chan_en`, `bus_req`, `dev_ack`, `mem_stb`, `mem_we` and `done` are all 0.
- R2: A write with `cfg_sel`=0 loads the control word. Bit 0 is enable, bit 1 is level activation (1 = level sensed), bit 2 is size (0 = byte, 1 = 16-bit word) and bit 3 is direction (1 = memory write, 0 = memory read). `cfg_sel`=1 loads the memory address and `cfg_sel`=2 loads the transfer count. `chan_en` shows the enable bit from the cycle after the write edge.
- R3: The first request sample is taken at the rising edge after the enable write edge. If the request is held low and grant is immediate, the first transfer cycle is the cycle that starts three edges after the write edge.
- R4: After a request is latched, `bus_req` rises on the next edge. The transfer cycle begins on the edge after grant is seen, so at least two cycles separate the latch from the transfer. While grant is withheld, no transfer occurs.
- R5: A transfer lasts exactly one cycle. In it `mem_stb` and `dev_ack` are both high and `bus_gnt` is high. `bus_req` is low in the following cycle.
- R6: The request line is not sampled while the channel waits for grant, transfers or sits in the bus break. A low level present only in those cycles causes no transfer.
- R7: With the level-activation bit 0, the request line is ignored and `bus_req` stays low.
- R8: When the transfer that takes the count from 1 to 0 ends, `chan_en` clears and `done` is high for exactly one cycle. No further transfers follow, even with the request held low.
- R9: `mem_addr` holds the programmed address during the first transfer and advances by 1 (byte) or 2 (word) after each transfer.
- R10: `mem_we` is high during a transfer only when the direction bit is 1, and is never high outside a transfer.
- R11: With the request held low and immediate grant, transfers repeat every five cycles until the count ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| cfg_wdata | input | AW | Register write data |
| ext_req_n | input | 1 | Active-low device request |
| dev_ack | output | 1 | Device acknowledge during the transfer cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory address |
| mem_stb | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| chan_en | output | 1 | Channel enable state |
| done | output | 1 | One-cycle pulse at the end of the last transfer |

## Verification
The bound checker watches the bus handshake on every cycle. It checks that a transfer happens only under grant after a request cycle, that it lasts one cycle and is followed by a bus break, that the write strobe stays inside transfers, that done is a single-cycle pulse with the enable already clear, and that the channel is idle after reset. The exact start latency after the enable write, the five-cycle repeat rate, the address stepping, and the rule that requests arriving during a busy window or in the wrong mode are ignored all depend on the stimulus history. Only the directed scenarios in the bench can show those.

// File: rtl/dma_lvl_chan.sv
module dma_lvl_chan #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          ext_req_n,
  output logic          dev_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_stb,
  output logic          mem_we,
  output logic          chan_en,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_ARB, S_XFER, S_BRK} st_t;

  st_t           st;
  logic          en, lvl, wsz, tomem, pend, done_q;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;

  wire sample = en & lvl & ~pend & (st == S_IDLE);
  wire last   = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      en     <= 1'b0;
      lvl    <= 1'b0;
      wsz    <= 1'b0;
      tomem  <= 1'b0;
      pend   <= 1'b0;
      done_q <= 1'b0;
      addr   <= '0;
      cnt    <= '0;
    end else begin
      done_q <= 1'b0;
      if (sample && !ext_req_n) pend <= 1'b1;
      case (st)
        S_IDLE: if (pend) begin
          pend <= 1'b0;
          if (en) st <= S_ARB;
        end
        S_ARB:  if (bus_gnt) st <= S_XFER;
        S_XFER: begin
          st   <= S_BRK;
          addr <= addr + (wsz ? AW'(2) : AW'(1));
          cnt  <= cnt - CW'(1);
          if (last) begin
            en     <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: {tomem, wsz, lvl, en} <= cfg_wdata[3:0];
          2'd1: addr <= cfg_wdata;
          2'd2: cnt  <= cfg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign mem_stb  = (st == S_XFER);
  assign dev_ack  = mem_stb;
  assign mem_we   = mem_stb & tomem;
  assign bus_req  = (st == S_ARB) | (st == S_XFER);
  assign mem_addr = addr;
  assign chan_en  = en;
  assign done     = done_q;
endmodule

// File: rtl/dma_lvl_chan_chk.sv
module dma_lvl_chan_chk (
  input logic clk,
  input logic rst,
  input logic bus_req,
  input logic bus_gnt,
  input logic mem_stb,
  input logic mem_we,
  input logic chan_en,
  input logic done
);
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!bus_req && !chan_en && !mem_stb && !done));

  a_r5_stb_under_grant: assert property (@(posedge clk) disable iff (rst)
    mem_stb |-> (bus_gnt && bus_req));

  a_r5_single_cycle_break: assert property (@(posedge clk) disable iff (rst)
    mem_stb |=> (!mem_stb && !bus_req));

  a_r4_request_first: assert property (@(posedge clk) disable iff (rst)
    mem_stb |-> $past(bus_req));

  a_r10_we_in_xfer: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_stb);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_disabled: assert property (@(posedge clk) disable iff (rst)
    done |-> !chan_en);
endmodule

bind dma_lvl_chan dma_lvl_chan_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_stb(mem_stb), .mem_we(mem_we), .chan_en(chan_en), .done(done)
);

// File: tb/dma_lvl_chan_bench.sv
module dma_lvl_chan_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          ext_req_n = 1'b1;
  logic          gnt_ok = 1'b1;
  logic          dev_ack, bus_req, bus_gnt, mem_stb, mem_we, chan_en, done;
  logic [AW-1:0] mem_addr;

  assign bus_gnt = bus_req & gnt_ok;

  dma_lvl_chan #(.AW(AW), .CW(16)) u_dma_lvl_chan (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_req_n(ext_req_n), .dev_ack(dev_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_stb(mem_stb), .mem_we(mem_we), .chan_en(chan_en), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int ecnt = 0;
  int nx = 0, ndone = 0, nreq = 0, bad5 = 0;
  logic [AW-1:0] log_addr [8];
  logic          log_we   [8];
  int            log_cyc  [8];
  logic          prev_stb = 1'b0;

  always @(posedge clk) ecnt <= ecnt + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_stb && nx < 8) begin
        log_addr[nx] = mem_addr;
        log_we[nx]   = mem_we;
        log_cyc[nx]  = ecnt;
      end
      if (mem_stb) nx++;
      if (done) ndone++;
      if (bus_req) nreq++;
      if ((dev_ack != mem_stb) || (mem_stb && !bus_gnt) || (prev_stb && bus_req)) bad5++;
      prev_stb = mem_stb;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = AW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ext_req_n = 1'b1; gnt_ok = 1'b1; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nx = 0; ndone = 0; nreq = 0; prev_stb = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 chan_en", chan_en, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 ack/stb/we/done", {dev_ack, mem_stb, mem_we, done}, 0);
  endtask

  task automatic t_byte_read();
    int w;
    do_reset();
    ext_req_n = 1'b0;
    wr(2'd1, 'h100);
    wr(2'd2, 3);
    wr(2'd0, 'b0011);
    w = ecnt;
    chk("R2 chan_en after write", chan_en, 1);
    repeat (25) @(negedge clk);
    chk("R8 transfer count", nx, 3);
    chk("R3 first transfer latency", log_cyc[0] - w, 3);
    chk("R11 repeat period", log_cyc[1] - log_cyc[0], 5);
    chk("R11 repeat period 2", log_cyc[2] - log_cyc[1], 5);
    chk("R9 addr 0", int'(log_addr[0]), 'h100);
    chk("R9 addr 2 byte step", int'(log_addr[2]), 'h102);
    chk("R10 read no we", int'(log_we[0]) + int'(log_we[1]) + int'(log_we[2]), 0);
    chk("R8 done pulses", ndone, 1);
    chk("R8 enable cleared", chan_en, 0);
  endtask

  task automatic t_word_write();
    do_reset();
    ext_req_n = 1'b0;
    wr(2'd1, 'h200);
    wr(2'd2, 2);
    wr(2'd0, 'b1111);
    repeat (25) @(negedge clk);
    chk("R8 word count", nx, 2);
    chk("R9 word addr 0", int'(log_addr[0]), 'h200);
    chk("R9 word addr 1", int'(log_addr[1]), 'h202);
    chk("R10 write we", int'(log_we[0]) + int'(log_we[1]), 2);
    chk("R8 single done", ndone, 1);
  endtask

  task automatic t_grant_delay();
    int g;
    do_reset();
    gnt_ok = 1'b0;
    ext_req_n = 1'b0;
    wr(2'd2, 1);
    wr(2'd0, 'b0011);
    repeat (8) @(negedge clk);
    chk("R4 no transfer without grant", nx, 0);
    chk("R4 bus_req held", bus_req, 1);
    gnt_ok = 1'b1;
    g = ecnt;
    repeat (6) @(negedge clk);
    chk("R4 transfer after grant", nx, 1);
    chk("R4 transfer edge after grant", log_cyc[0] - g, 1);
  endtask

  task automatic t_mode_off();
    do_reset();
    ext_req_n = 1'b0;
    wr(2'd2, 4);
    wr(2'd0, 'b0001);
    repeat (20) @(negedge clk);
    chk("R7 bus_req never raised", nreq, 0);
    chk("R7 no transfer", nx, 0);
  endtask

  task automatic t_busy_ignore();
    do_reset();
    wr(2'd2, 2);
    wr(2'd0, 'b0011);
    ext_req_n = 1'b0;
    repeat (5) @(negedge clk);
    ext_req_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 busy-window request ignored", nx, 1);
    chk("R6 channel still enabled", chan_en, 1);
    chk("R6 no done", ndone, 0);
    chk("R5 handshake shape", bad5, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_byte_read();
    t_word_write();
    t_grant_delay();
    t_mode_off();
    t_busy_ignore();
    chk("R5 ack equals strobe under grant", bad5, 0);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule